// File: doc/BRIEF.md
# Seven-Level Multicarrier PWM Gate Generator

This block produces the six switch gates for a seven-level inverter. The inverter pairs a level stage, built from two DC sources in a 1:2 voltage ratio, with a full bridge that sets the polarity. Internally, a sampled sine reference is compared against six triangular carriers that are stacked one band height apart. Three carriers sit above zero and three below. The six comparison bits form a thermometer code. That code is decoded into a signed output level from -3 to +3, into the two level-stage gates, and into the four bridge gates.

A two-bit selector picks how the carriers are phased against each other: all in phase, the lower three opposed to the upper three, or each carrier opposed to its neighbour. A modulation index scales the reference peak. Each reference period spans 40 carrier periods. A change to the selector or to the index is taken up only at the start of a new reference period, or at any time while the block is disabled. All outputs are registered.

Top module: `mpwm_gate_gen`

## Requirements
- R1: While `rst` is high, or on the edge after `en` is sampled low, every gate bit, every band bit and `level` are 0. Dropping `en` also returns the reference and carrier phase to the start of a period.
- R2: One carrier period lasts 2·2^BAND_W clocks, and 40 carrier periods make one reference period. The reference is resampled once, at the first clock of each carrier period. With the defaults, the output sampled after the n-th enabled edge reflects carrier tick n mod 32 and reference step (n div 32) mod 40.
- R3: `band_out[i]` is 1 when the reference is above carrier i. Position 0 is the lowest band (-3 to -2 heights) and position 5 the highest (+2 to +3 heights). The carriers take values band offset + r, with r from 0 to 2^BAND_W-1.
- R4: `level` equals the number of upper bands (bits 5..3) that are set, minus the number of lower bands (bits 2..0) that are clear. This is the count of ones in `band_out` minus 3.
- R5: `gate_lvl[0]` (the single-unit source) is on when |level| is 1 or 3. `gate_lvl[1]` (the double-unit source) is on when |level| is 2 or 3.
- R6: During reference steps 0 to 19 `gate_br` is 4'b1001, and during steps 20 to 39 it is 4'b0110, zero-level intervals included. The two pairs are never on together.
- R7: `arr_sel` 0 puts all carriers in phase. `arr_sel` 1 inverts the direction of bands 0..2. `arr_sel` 2 inverts bands 1, 3 and 5. `arr_sel` 3 behaves as 0. An uninverted carrier has r = 0 at the first tick of a period and rises for half the period.
- R8: `arr_sel` and `mod_index` are captured only at a reference period boundary, or on any clock while `en` is low.
- R9: The reference peak is `mod_index`/256 × 3 band heights, truncated toward zero, with a sign set by the half cycle. With index 0 the bands hold 6'b000111 and the level is 0. Index 256 reaches levels +3 and -3, and index 128 reaches +2 and -2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds phase at zero and gates off |
| arr_sel | input | 2 | Carrier phase arrangement select |
| mod_index | input | MI_W (9) | Modulation index, 256 = full scale |
| band_out | output | 6 | Registered band comparison bits, bit 0 lowest |
| gate_lvl | output | 2 | Level-stage gates: bit 0 one-unit, bit 1 two-unit |
| gate_br | output | 4 | Bridge gates: bits 0,3 positive pair, bits 1,2 negative pair |
| level | output | 3 | Signed output level code, -3 to +3 |

## Verification
Some properties are checked on every enabled cycle by assertions: the band bits always form a thermometer code, the bridge pairs never overlap, the level-stage gates and bridge polarity agree with the level code, the captured arrangement and index stay put inside a period, and disable or reset clears the gates. Other behaviour depends on where the reference and the carriers sit in time, and only the bench scenarios show it. These include the exact band pattern and level at chosen ticks, the distinct level each phase arrangement gives at the same instant, the peak level reached for a given index, and the deferral of a selector change to the next period.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;

    localparam int STEPS_PER_CYCLE = 40;
    localparam int QUARTER         = STEPS_PER_CYCLE / 4;
    localparam int SINE_W          = 16;
    localparam int SINE_FRAC       = 15;
    localparam int NBANDS          = 6;

    typedef enum logic [1:0] {
        ARR_INPHASE   = 2'd0,
        ARR_OPPOSED   = 2'd1,
        ARR_ALTERNATE = 2'd2
    } arr_mode_e;

    typedef struct packed {
        logic [1:0] lvl_sw;
        logic [3:0] br_sw;
    } gate_t;

    // sin(idx * 9 deg) in Q1.15, idx 0..10
    function automatic logic [SINE_W-1:0] sine_q15(input logic [3:0] idx);
        case (idx)
            4'd0:    return 16'd0;
            4'd1:    return 16'd5126;
            4'd2:    return 16'd10126;
            4'd3:    return 16'd14876;
            4'd4:    return 16'd19260;
            4'd5:    return 16'd23170;
            4'd6:    return 16'd26509;
            4'd7:    return 16'd29196;
            4'd8:    return 16'd31163;
            4'd9:    return 16'd32364;
            4'd10:   return 16'd32767;
            default: return 16'd0;
        endcase
    endfunction

    // whether carrier at stack position pos runs in the inverted direction
    function automatic logic band_inverted(input logic [1:0] mode, input int pos);
        case (arr_mode_e'(mode))
            ARR_OPPOSED:   return (pos < NBANDS / 2);
            ARR_ALTERNATE: return (pos % 2) == 1;
            default:       return 1'b0;
        endcase
    endfunction

    function automatic logic signed [2:0] level_of(input logic [NBANDS-1:0] b);
        logic [3:0] n;
        n = '0;
        for (int i = 0; i < NBANDS; i++) n = n + 4'(b[i]);
        return 3'(n - 4'd3);
    endfunction

endpackage

// File: rtl/mpwm_refgen.sv
module mpwm_refgen
    import mpwm_pkg::*;
#(
    parameter int BAND_W  = 4,
    parameter int MI_W    = 9,
    parameter int MI_FRAC = 8,
    parameter int REF_W   = BAND_W + (MI_W - MI_FRAC) + 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic [1:0]              mode_in,
    input  logic [MI_W-1:0]         mi_in,
    output logic [BAND_W:0]         tick,
    output logic [1:0]              mode_q,
    output logic signed [REF_W-1:0] ref_val,
    output logic                    neg_half
);
    localparam int BAND      = 2 ** BAND_W;
    localparam int STEP_W    = $clog2(STEPS_PER_CYCLE);
    localparam int PROD_W    = SINE_W + MI_W + BAND_W + 2;
    localparam int SHIFT     = SINE_FRAC + MI_FRAC;
    localparam int STEP_LAST = STEPS_PER_CYCLE - 1;

    logic [BAND_W:0]   tick_q;
    logic [STEP_W-1:0] step_q;
    logic [1:0]        mode_r;
    logic [MI_W-1:0]   mi_r;
    logic              period_end;
    logic              wrap;

    assign period_end = &tick_q;
    assign wrap       = period_end && (step_q == STEP_W'(STEP_LAST));

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= '0;
            step_q <= '0;
            mode_r <= ARR_INPHASE;
            mi_r   <= '0;
        end else if (!en) begin
            tick_q <= '0;
            step_q <= '0;
            mode_r <= mode_in;
            mi_r   <= mi_in;
        end else begin
            tick_q <= tick_q + 1'b1;
            if (period_end)
                step_q <= wrap ? '0 : step_q + 1'b1;
            if (wrap) begin
                mode_r <= mode_in;
                mi_r   <= mi_in;
            end
        end
    end

    logic [STEP_W-1:0] in_half;
    logic [3:0]        idx;
    logic [REF_W-2:0]  mag;

    always_comb begin
        neg_half = step_q >= STEP_W'(2 * QUARTER);
        in_half  = neg_half ? step_q - STEP_W'(2 * QUARTER) : step_q;
        idx      = (in_half <= STEP_W'(QUARTER)) ? 4'(in_half)
                                                  : 4'(STEP_W'(2 * QUARTER) - in_half);
        mag      = (REF_W-1)'((PROD_W'(sine_q15(idx)) * PROD_W'(mi_r)
                               * PROD_W'(3 * BAND)) >> SHIFT);
        ref_val  = neg_half ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end

    assign tick   = tick_q;
    assign mode_q = mode_r;

    // R8: captured settings only move at a period boundary or while disabled
    a_r8_settings_hold: assert property (@(posedge clk) disable iff (rst)
        (en && !wrap) |=> ($stable(mode_r) && $stable(mi_r)));

    // R2: reference step stays inside one reference period
    a_r2_step_range: assert property (@(posedge clk) disable iff (rst)
        step_q < STEP_W'(STEPS_PER_CYCLE));

endmodule

// File: rtl/mpwm_bands.sv
module mpwm_bands
    import mpwm_pkg::*;
#(
    parameter int BAND_W = 4,
    parameter int REF_W  = BAND_W + 4
) (
    input  logic [BAND_W:0]         tick,
    input  logic [1:0]              mode,
    input  logic signed [REF_W-1:0] ref_val,
    output logic [NBANDS-1:0]       band
);
    localparam int BAND = 2 ** BAND_W;

    logic [BAND_W-1:0] ramp;
    assign ramp = tick[BAND_W] ? ~tick[BAND_W-1:0] : tick[BAND_W-1:0];

    for (genvar g = 0; g < NBANDS; g++) begin : g_band
        localparam int OFF = (g - NBANDS / 2) * BAND;
        logic [BAND_W-1:0]       r;
        logic signed [REF_W-1:0] car;
        assign r       = band_inverted(mode, g) ? ~ramp : ramp;
        assign car     = REF_W'(OFF) + REF_W'(r);
        assign band[g] = ref_val > car;
    end

endmodule

// File: rtl/mpwm_gatedec.sv
module mpwm_gatedec
    import mpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [NBANDS-1:0] band_in,
    input  logic              neg_half,
    output logic [NBANDS-1:0] band_q,
    output logic signed [2:0] level_q,
    output gate_t             gate_q
);
    logic signed [2:0] lvl;
    logic [1:0]        amag;
    gate_t             gate_d;

    always_comb begin
        lvl            = level_of(band_in);
        amag           = 2'(lvl < 0 ? -lvl : lvl);
        gate_d.lvl_sw  = {amag[1], amag[0]};
        gate_d.br_sw   = neg_half ? 4'b0110 : 4'b1001;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            band_q  <= '0;
            level_q <= '0;
            gate_q  <= '0;
        end else begin
            band_q  <= band_in;
            level_q <= lvl;
            gate_q  <= gate_d;
        end
    end

    // R4: the band comparisons always form a thermometer from the bottom up
    a_r4_thermometer: assert property (@(posedge clk) disable iff (rst)
        en |-> ((band_in & (band_in + 1'b1)) == '0));

    // R6: the two bridge pairs are never on together
    a_r6_bridge_exclusive: assert property (@(posedge clk) disable iff (rst)
        !((gate_q.br_sw[0] | gate_q.br_sw[3]) & (gate_q.br_sw[1] | gate_q.br_sw[2])));

    // R6: bridge polarity agrees with the sign of the level
    a_r6_polarity_pos: assert property (@(posedge clk) disable iff (rst)
        (level_q > 0) |-> (gate_q.br_sw == 4'b1001));
    a_r6_polarity_neg: assert property (@(posedge clk) disable iff (rst)
        (level_q < 0) |-> (gate_q.br_sw == 4'b0110));

    // R5: a zero level uses neither source
    a_r5_zero_level: assert property (@(posedge clk) disable iff (rst)
        (level_q == 0) |-> (gate_q.lvl_sw == 2'b00));

    // R1: disable and reset clear every gate on the next edge
    a_r1_disable_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> (gate_q == '0));
    a_r1_reset_off: assert property (@(posedge clk)
        rst |=> (gate_q == '0 && level_q == 0));

endmodule

// File: rtl/mpwm_gate_gen.sv
module mpwm_gate_gen
    import mpwm_pkg::*;
#(
    parameter int BAND_W  = 4,
    parameter int MI_W    = 9,
    parameter int MI_FRAC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [1:0]        arr_sel,
    input  logic [MI_W-1:0]   mod_index,
    output logic [5:0]        band_out,
    output logic [1:0]        gate_lvl,
    output logic [3:0]        gate_br,
    output logic signed [2:0] level
);
    localparam int REF_W = BAND_W + (MI_W - MI_FRAC) + 3;

    logic [BAND_W:0]         tick;
    logic [1:0]              mode_q;
    logic signed [REF_W-1:0] ref_val;
    logic                    neg_half;
    logic [NBANDS-1:0]       band;
    gate_t                   gate_q;

    mpwm_refgen #(
        .BAND_W (BAND_W),
        .MI_W   (MI_W),
        .MI_FRAC(MI_FRAC),
        .REF_W  (REF_W)
    ) u_ref (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .mode_in (arr_sel),
        .mi_in   (mod_index),
        .tick    (tick),
        .mode_q  (mode_q),
        .ref_val (ref_val),
        .neg_half(neg_half)
    );

    mpwm_bands #(
        .BAND_W(BAND_W),
        .REF_W (REF_W)
    ) u_bands (
        .tick   (tick),
        .mode   (mode_q),
        .ref_val(ref_val),
        .band   (band)
    );

    mpwm_gatedec u_dec (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .band_in (band),
        .neg_half(neg_half),
        .band_q  (band_out),
        .level_q (level),
        .gate_q  (gate_q)
    );

    assign gate_lvl = gate_q.lvl_sw;
    assign gate_br  = gate_q.br_sw;

endmodule

// File: tb/mpwm_gate_gen_test.sv
`timescale 1ns/1ps
module mpwm_gate_gen_test;

    logic              clk = 1'b0;
    logic              rst;
    logic              en;
    logic [1:0]        arr_sel;
    logic [8:0]        mod_index;
    logic [5:0]        band_out;
    logic [1:0]        gate_lvl;
    logic [3:0]        gate_br;
    logic signed [2:0] level;

    int n_pass = 0;
    int n_fail = 0;
    int n_now  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    mpwm_gate_gen uut (
        .clk(clk), .rst(rst), .en(en), .arr_sel(arr_sel), .mod_index(mod_index),
        .band_out(band_out), .gate_lvl(gate_lvl), .gate_br(gate_br), .level(level)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        if (ok) n_pass++;
        else begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (sample %0d)", tag, act, exp, n_now);
        end
    endtask

    task automatic tick1();
        @(posedge clk);
        @(negedge clk);
        n_now++;
    endtask

    task automatic start(input logic [1:0] mode, input logic [8:0] mi);
        en        = 1'b0;
        arr_sel   = mode;
        mod_index = mi;
        @(posedge clk);
        @(negedge clk);
        en    = 1'b1;
        n_now = -1;
    endtask

    task automatic go(input int target);
        while (n_now < target) tick1();
    endtask

    function automatic int ones(input logic [5:0] b);
        int c = 0;
        for (int i = 0; i < 6; i++) c += int'(b[i]);
        return c;
    endfunction

    function automatic int lv();
        return int'(level);
    endfunction

    task automatic t_reset();
        rst = 1'b1; en = 1'b1; arr_sel = 2'd0; mod_index = 9'd256;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(gate_lvl == 2'b00 && gate_br == 4'b0000, "R1 reset gates", {gate_lvl, gate_br}, 0);
        chk(band_out == 6'b0 && level == 3'sd0, "R1 reset bands/level", band_out, 0);
        rst = 1'b0;
    endtask

    task automatic t_zero_index();
        int bad_band = 0;
        int bad_br   = 0;
        start(2'd0, 9'd0);
        for (int n = 0; n < 1280; n++) begin
            go(n);
            if (band_out != 6'b000111 || level != 3'sd0 || gate_lvl != 2'b00) bad_band++;
            if (gate_br != ((n / 32) >= 20 ? 4'b0110 : 4'b1001)) bad_br++;
        end
        chk(bad_band == 0, "R9 zero index holds level 0 pattern", bad_band, 0);
        chk(bad_br == 0, "R6 bridge follows half cycle at zero level", bad_br, 0);
    endtask

    task automatic t_sweep(input logic [1:0] mode, input logic [8:0] mi,
                           input int exp_max, input int exp_min);
        int mx = -9, mn = 9;
        int bad4 = 0, bad5 = 0, bad6 = 0;
        start(mode, mi);
        for (int n = 0; n < 1280; n++) begin
            int a, l;
            bit neg;
            go(n);
            l   = lv();
            neg = (n / 32) >= 20;
            a   = l < 0 ? -l : l;
            if (l != ones(band_out) - 3) bad4++;
            if (gate_lvl[0] != (a == 1 || a == 3) || gate_lvl[1] != (a == 2 || a == 3)) bad5++;
            if (gate_br != (neg ? 4'b0110 : 4'b1001)) bad6++;
            if ((l > 0 && neg) || (l < 0 && !neg)) bad6++;
            if (l > mx) mx = l;
            if (l < mn) mn = l;
        end
        chk(bad4 == 0, "R4 level from band count", bad4, 0);
        chk(bad5 == 0, "R5 level-stage gates from magnitude", bad5, 0);
        chk(bad6 == 0, "R6 bridge polarity by half cycle", bad6, 0);
        chk(mx == exp_max, "R9 peak positive level", mx, exp_max);
        chk(mn == exp_min, "R9 peak negative level", mn, exp_min);
    endtask

    task automatic t_timing();
        start(2'd0, 9'd256);
        go(31);  chk(lv() == 0, "R2 last tick of first carrier period", lv(), 0);
        go(32);  chk(lv() == 1, "R2 reference resampled at period start", lv(), 1);
        go(320); chk(band_out == 6'b111111, "R3 band bits at positive crest", band_out, 6'h3f);
        go(639); chk(lv() == 1 && gate_br == 4'b1001, "R2 last step of positive half", lv(), 1);
        go(640); chk(lv() == 0 && gate_br == 4'b0110, "R6 negative half starts at step 20", gate_br, 6);
        go(960); chk(band_out == 6'b000001, "R3 band bits at negative crest", band_out, 1);
    endtask

    task automatic t_probe(input logic [1:0] mode, input int exp_pos, input int exp_neg);
        start(mode, 9'd64);
        go(320); chk(lv() == exp_pos, $sformatf("R7 arrangement %0d upper crest", mode), lv(), exp_pos);
        go(960); chk(lv() == exp_neg, $sformatf("R7 arrangement %0d lower crest", mode), lv(), exp_neg);
    endtask

    task automatic t_deferred();
        start(2'd0, 9'd64);
        go(400);
        arr_sel = 2'd1;
        go(960);  chk(lv() == 0, "R8 arrangement change waits for boundary", lv(), 0);
        go(2240); chk(lv() == -1, "R8 arrangement applied next period", lv(), -1);
        go(2300);
        mod_index = 9'd256;
        go(2560 + 320); chk(lv() == 3, "R8 index applied next period", lv(), 3);
    endtask

    task automatic t_disable();
        start(2'd0, 9'd256);
        go(330);
        en = 1'b0;
        tick1();
        chk(gate_lvl == 2'b00 && gate_br == 4'b0000, "R1 disable clears gates", {gate_lvl, gate_br}, 0);
        chk(band_out == 6'b0 && level == 3'sd0, "R1 disable clears bands/level", band_out, 0);
        en = 1'b1;
        n_now = -1;
        go(31); chk(lv() == 0, "R1 restart from period start", lv(), 0);
        go(32); chk(lv() == 1, "R1 restart step 1", lv(), 1);
    endtask

    initial begin
        t_reset();
        t_zero_index();
        t_sweep(2'd0, 9'd256, 3, -3);
        t_sweep(2'd1, 9'd128, 2, -2);
        t_sweep(2'd2, 9'd256, 3, -3);
        t_timing();
        t_probe(2'd0, 1, 0);
        t_probe(2'd1, 1, -1);
        t_probe(2'd2, 0, 0);
        t_probe(2'd3, 1, 0);
        t_deferred();
        t_disable();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
            $finish;
        end
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
            $finish;
        end
    end

endmodule